// File: doc/BRIEF.md
# Transceiver Control Latch Bank

This block keeps the per-channel control settings of a two-channel serial transceiver. A single 4-bit control bus is shared by three groups of settings. The first group enables the serial output drivers. The second switches the receive channel power on and off. The third chooses between the built-in self-test and normal traffic. Each group has its own active-high latch enable. While that enable is high, the group follows the bus. When the enable falls, the group keeps the last bus value it saw. Several enables may be high together, and each of them then takes the same bus value.

The block is modelled in one clock domain. Each group loads the bus on every clock edge while its enable is high. Its output is the live bus while the enable is high and the stored value otherwise. The active-low reset disables every serial driver and powers down both receive channels. It also forces the self-test group to the test-off state, but only while that group's enable is low. For each receive channel the block drives an active-low link fault output. That output combines three registered status inputs with the channel's own power bit.

There is no data stream through the block. All pins are plain control and status signals, so no valid/ready handshake exists and no back-pressure rules apply.

Top module: `ctlbank_top`

## Requirements
- R1: While an enable (`le_oe`, `le_rx`, `le_bist`) is high, the outputs of its group equal the current `ctl_bus` in the same cycle, with no clock edge needed.
- R2: After an enable falls, its group keeps the bus value present at the last rising clock edge while the enable was high. Later changes on `ctl_bus` have no effect on it.
- R3: `oe_en[i]` follows bus bit i. A value of 1 enables the driver and 0 powers it down. Bits 1:0 serve channel A's two outputs and bits 3:2 serve channel B's.
- R4: `rx_pwr[0]` follows bus bit 0 (channel A) and `rx_pwr[1]` follows bus bit 2 (channel B). A value of 1 means powered and 0 means power-save. Bus bits 1 and 3 have no effect on `rx_pwr`.
- R5: `bist_norm[i]` follows bus bit i with inverted meaning: 0 selects self-test and 1 selects normal traffic. Bit 0 is transmit A, bit 1 is receive A, bit 2 is transmit B and bit 3 is receive B.
- R6: While `rst_n` is low, `oe_en` and `rx_pwr` read 0 whatever the enables are. Both groups stay 0 after release until they are loaded again.
- R7: While `rst_n` is low and `le_bist` is low, `bist_norm` reads 4'b1111. While `le_bist` is high, reset has no effect on that group and it follows the bus.
- R8: `link_fault_n[c]` is 0 when the channel's power bit is 0, with no delay. It is also 0 one clock edge after any of `freq_bad[c]`, `amp_low[c]` or `dens_low[c]` is sampled high. Otherwise it is 1.
- R9: When more than one enable is high, each selected group takes the same bus value in the same cycle and keeps it after its enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_bus | input | 4 | Shared control bus |
| le_oe | input | 1 | Latch enable, serial output group |
| le_rx | input | 1 | Latch enable, receive power group |
| le_bist | input | 1 | Latch enable, self-test group |
| freq_bad | input | 2 | Per channel: received frequency out of range |
| amp_low | input | 2 | Per channel: signal amplitude too low |
| dens_low | input | 2 | Per channel: transition density too low |
| oe_en | output | 4 | Serial driver enables, 1 = on |
| rx_pwr | output | 2 | Receive channel power, 1 = active |
| bist_norm | output | 4 | Self-test select, 0 = self-test, 1 = normal |
| link_fault_n | output | 2 | Per-channel link fault, active low |

## Verification
The hardest case to reach is the reset exception of the self-test group. Reset must be held low while `le_bist` is high and the bus carries a value other than all ones. Then `le_bist` must fall while reset is still low, and at that moment the group must switch to all ones. The bench gets there by loading a self-test pattern, asserting reset with the enable held open, and then closing the enable before reset is released. It checks at each step that the output and receive groups stay at zero throughout.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;
  localparam int unsigned BUS_W  = 4;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned LANE_W = BUS_W / NUM_CH;
  localparam logic [BUS_W-1:0] BIST_OFF_VAL = '1;
endpackage

// File: rtl/ctlbank_latch_set.sv
module ctlbank_latch_set #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter bit RST_ONLY_CLOSED = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;
  logic         rst_hit;

  generate
    if (RST_ONLY_CLOSED) begin : g_gated_rst
      assign rst_hit = !rst_n && !le;
    end else begin : g_plain_rst
      assign rst_hit = !rst_n;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst_hit)  held <= RST_VAL;
    else if (le)  held <= d;
  end

  assign q = rst_hit ? RST_VAL : (le ? d : held);
endmodule

// File: rtl/ctlbank_fault.sv
module ctlbank_fault #(
  parameter int unsigned NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] freq_bad,
  input  logic [NCH-1:0] amp_low,
  input  logic [NCH-1:0] dens_low,
  input  logic [NCH-1:0] rx_on,
  output logic [NCH-1:0] fault_n
);
  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic freq_q, amp_q, dens_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          freq_q <= 1'b0;
          amp_q  <= 1'b0;
          dens_q <= 1'b0;
        end else begin
          freq_q <= freq_bad[c];
          amp_q  <= amp_low[c];
          dens_q <= dens_low[c];
        end
      end
      assign fault_n[c] = !(freq_q || amp_q || dens_q || !rx_on[c]);
    end
  endgenerate
endmodule

// File: rtl/ctlbank_top.sv
module ctlbank_top
  import ctlbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_W-1:0]  ctl_bus,
  input  logic              le_oe,
  input  logic              le_rx,
  input  logic              le_bist,
  input  logic [NUM_CH-1:0] freq_bad,
  input  logic [NUM_CH-1:0] amp_low,
  input  logic [NUM_CH-1:0] dens_low,
  output logic [BUS_W-1:0]  oe_en,
  output logic [NUM_CH-1:0] rx_pwr,
  output logic [BUS_W-1:0]  bist_norm,
  output logic [NUM_CH-1:0] link_fault_n
);
  logic [NUM_CH-1:0] rx_bus;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_rx_pick
      assign rx_bus[c] = ctl_bus[c*LANE_W];
    end
  endgenerate

  ctlbank_latch_set #(.W(BUS_W), .RST_VAL('0), .RST_ONLY_CLOSED(1'b0)) u_oe (
    .clk(clk), .rst_n(rst_n), .le(le_oe), .d(ctl_bus), .q(oe_en)
  );

  ctlbank_latch_set #(.W(NUM_CH), .RST_VAL('0), .RST_ONLY_CLOSED(1'b0)) u_rx (
    .clk(clk), .rst_n(rst_n), .le(le_rx), .d(rx_bus), .q(rx_pwr)
  );

  ctlbank_latch_set #(.W(BUS_W), .RST_VAL(BIST_OFF_VAL), .RST_ONLY_CLOSED(1'b1)) u_bist (
    .clk(clk), .rst_n(rst_n), .le(le_bist), .d(ctl_bus), .q(bist_norm)
  );

  ctlbank_fault #(.NCH(NUM_CH)) u_fault (
    .clk(clk), .rst_n(rst_n), .freq_bad(freq_bad), .amp_low(amp_low),
    .dens_low(dens_low), .rx_on(rx_pwr), .fault_n(link_fault_n)
  );
endmodule

// File: rtl/ctlbank_checker.sv
module ctlbank_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ctl_bus,
  input logic       le_oe,
  input logic       le_rx,
  input logic       le_bist,
  input logic [3:0] oe_en,
  input logic [1:0] rx_pwr,
  input logic [3:0] bist_norm,
  input logic [1:0] link_fault_n
);
  AST_OE_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    le_oe |-> oe_en == ctl_bus); // R1
  AST_RX_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    le_rx |-> rx_pwr == {ctl_bus[2], ctl_bus[0]}); // R4
  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !le_oe |=> (le_oe || $stable(oe_en))); // R2
  AST_BIST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(le_bist) |-> bist_norm == $past(ctl_bus)); // R2
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (oe_en == 4'h0 && rx_pwr == 2'b00)); // R6
  AST_BIST_RESET_GATED: assert property (@(posedge clk)
    (!rst_n && !le_bist) |-> bist_norm == 4'hF); // R7
  AST_BIST_OPEN_IN_RESET: assert property (@(posedge clk)
    (!rst_n && le_bist) |-> bist_norm == ctl_bus); // R7
  AST_FAULT_WHEN_OFF_A: assert property (@(posedge clk)
    !rx_pwr[0] |-> !link_fault_n[0]); // R8
  AST_FAULT_WHEN_OFF_B: assert property (@(posedge clk)
    !rx_pwr[1] |-> !link_fault_n[1]); // R8
endmodule

bind ctlbank_top ctlbank_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_bus(ctl_bus), .le_oe(le_oe), .le_rx(le_rx),
  .le_bist(le_bist), .oe_en(oe_en), .rx_pwr(rx_pwr), .bist_norm(bist_norm),
  .link_fault_n(link_fault_n)
);

// File: tb/ctlbank_top_test.sv
module ctlbank_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ctl_bus = 4'h0;
  logic       le_oe = 1'b0, le_rx = 1'b0, le_bist = 1'b0;
  logic [1:0] freq_bad = 2'b00, amp_low = 2'b00, dens_low = 2'b00;
  logic [3:0] oe_en, bist_norm;
  logic [1:0] rx_pwr, link_fault_n;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ctlbank_top uut (
    .clk(clk), .rst_n(rst_n), .ctl_bus(ctl_bus), .le_oe(le_oe), .le_rx(le_rx),
    .le_bist(le_bist), .freq_bad(freq_bad), .amp_low(amp_low), .dens_low(dens_low),
    .oe_en(oe_en), .rx_pwr(rx_pwr), .bist_norm(bist_norm), .link_fault_n(link_fault_n)
  );

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    check("R6 oe in reset", oe_en, 4'h0);
    check("R6 rx in reset", {2'b00, rx_pwr}, 4'h0);
    check("R7 bist in reset", bist_norm, 4'hF);
    check("R8 fault with rx off", {2'b00, link_fault_n}, 4'h0);
    step();
    rst_n = 1'b1;
    step();
    #1;
    check("R6 oe after release", oe_en, 4'h0);
  endtask

  task automatic t_oe();
    le_oe = 1'b1; ctl_bus = 4'b1010; #1;
    check("R1 R3 oe live", oe_en, 4'b1010);
    ctl_bus = 4'b0101; #1;
    check("R1 R3 oe live change", oe_en, 4'b0101);
    step();
    le_oe = 1'b0; ctl_bus = 4'b1110; #1;
    check("R2 oe captured", oe_en, 4'b0101);
    step(); ctl_bus = 4'b0000; #1;
    check("R2 oe ignores bus", oe_en, 4'b0101);
  endtask

  task automatic t_rx();
    le_rx = 1'b1; ctl_bus = 4'b0101; #1;
    check("R4 rx both on", {2'b00, rx_pwr}, 4'b0011);
    ctl_bus = 4'b1010; #1;
    check("R4 rx odd bits ignored", {2'b00, rx_pwr}, 4'b0000);
    ctl_bus = 4'b0100;
    step();
    le_rx = 1'b0; ctl_bus = 4'b0001; #1;
    check("R2 R4 rx captured", {2'b00, rx_pwr}, 4'b0010);
  endtask

  task automatic t_bist();
    le_bist = 1'b1; ctl_bus = 4'b1100; #1;
    check("R5 bist live", bist_norm, 4'b1100);
    step();
    le_bist = 1'b0; ctl_bus = 4'b0011; #1;
    check("R2 R5 bist captured", bist_norm, 4'b1100);
  endtask

  task automatic t_multi();
    le_oe = 1'b1; le_rx = 1'b1; le_bist = 1'b1; ctl_bus = 4'b0011;
    step();
    le_oe = 1'b0; le_rx = 1'b0; le_bist = 1'b0; ctl_bus = 4'b1000; #1;
    check("R9 oe shared load", oe_en, 4'b0011);
    check("R9 rx shared load", {2'b00, rx_pwr}, 4'b0001);
    check("R9 bist shared load", bist_norm, 4'b0011);
  endtask

  task automatic t_fault();
    le_rx = 1'b1; ctl_bus = 4'b0101;
    step();
    le_rx = 1'b0; #1;
    check("R8 no fault", {2'b00, link_fault_n}, 4'b0011);
    freq_bad = 2'b01; #1;
    check("R8 status registered", {2'b00, link_fault_n}, 4'b0011);
    step(); #1;
    check("R8 freq fault A", {2'b00, link_fault_n}, 4'b0010);
    freq_bad = 2'b00; amp_low = 2'b10;
    step(); #1;
    check("R8 amp fault B", {2'b00, link_fault_n}, 4'b0001);
    amp_low = 2'b00; dens_low = 2'b01;
    step(); #1;
    check("R8 density fault A", {2'b00, link_fault_n}, 4'b0010);
    dens_low = 2'b00;
    step(); #1;
    check("R8 fault cleared", {2'b00, link_fault_n}, 4'b0011);
    le_rx = 1'b1; ctl_bus = 4'b0001; #1;
    check("R8 rx B off", {2'b00, link_fault_n}, 4'b0001);
    step();
    le_rx = 1'b0;
  endtask

  task automatic t_reset_gate();
    rst_n = 1'b0; #1;
    check("R6 oe cleared", oe_en, 4'h0);
    check("R6 rx cleared", {2'b00, rx_pwr}, 4'h0);
    check("R7 bist forced off", bist_norm, 4'hF);
    le_bist = 1'b1; ctl_bus = 4'b0101; #1;
    check("R7 bist open ignores reset", bist_norm, 4'b0101);
    step(); #1;
    check("R7 bist open after edge", bist_norm, 4'b0101);
    le_oe = 1'b1; #1;
    check("R6 oe held in reset", oe_en, 4'h0);
    le_oe = 1'b0; le_bist = 1'b0; #1;
    check("R7 bist closed in reset", bist_norm, 4'hF);
    step();
    rst_n = 1'b1;
    step(); #1;
    check("R7 bist after release", bist_norm, 4'hF);
    check("R6 rx after release", {2'b00, rx_pwr}, 4'h0);
  endtask

  initial begin
    fork
      begin
        @(negedge clk);
        t_reset();
        t_oe();
        t_rx();
        t_bist();
        t_multi();
        t_fault();
        t_reset_gate();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule